// File: doc/BRIEF.md
# Transposable Weight-Tile MAC Engine

This engine keeps a ROWS x COLS tile of signed weights in a register array that is addressed by row and column. A run multiplies a streamed operand vector against that tile in one of two directions. The forward direction treats the stream as one value per row and produces one sum per column. The backward direction treats the stream as one value per column and produces one sum per row. Both directions read the same stored layout, so the tile is never copied or transposed.

A run begins with a start pulse while the engine is idle, and the direction and operand width are latched at that moment. Operands then arrive one per cycle over a valid/ready handshake. Every output lane multiplies and accumulates in parallel. An operand that is zero adds nothing, yet it still uses its cycle, so the latency of a run does not depend on the data. The sums are then presented one per cycle, and a done pulse follows the last of them. Weights are written through a simple write port, and that port only takes effect while no run is active.

Top module: `wtile_mac_engine`

## Requirements
- R1: With `bwd_mode`=0 latched at start, the engine accepts ROWS operands x[i] and then outputs COLS results in which result j equals the sum over i of x[i]*W[i][j]. Everything is signed two's complement, and W[i][j] is the weight written with `wr_row`=i and `wr_col`=j.
- R2: With `bwd_mode`=1 latched at start, the engine accepts COLS operands e[j] and then outputs ROWS results in which result i equals the sum over j of e[j]*W[i][j]. It uses the same stored weights as R1.
- R3: A weight write takes effect only while the engine is idle. A write issued during a run changes neither that run nor any later run.
- R4: With `narrow_mode`=1 latched at start, each operand and each weight is reduced to its low 8 bits, sign-extended, before it is multiplied. With `narrow_mode`=0, all 16 bits are used.
- R5: A zero operand adds nothing to the sums but still takes one cycle. `in_ready` stays high throughout the stream phase. `out_valid` rises in the cycle right after the last operand is accepted.
- R6: Every accumulator is cleared at start, so no run's results depend on an earlier run.
- R7: Results appear with `out_valid` high for consecutive cycles, with `out_idx` counting up from 0. `done` is high for exactly one cycle, the cycle right after the last result.
- R8: After reset, `in_ready`, `out_valid` and `done` are 0. A start pulse is ignored unless the engine is idle.
- R9: A cycle in which `in_valid` is low during the stream phase has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Weight write strobe |
| wr_row | input | RW | Row address of the weight write |
| wr_col | input | CW | Column address of the weight write |
| wr_data | input | OPW | Weight value to write |
| start | input | 1 | Starts a run when the engine is idle |
| bwd_mode | input | 1 | 0 selects forward, 1 selects backward (latched at start) |
| narrow_mode | input | 1 | 1 selects 8-bit operands (latched at start) |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Engine is accepting operands |
| in_data | input | OPW | Operand value |
| out_valid | output | 1 | A result is being presented |
| out_idx | output | IW | Index of the presented result |
| out_data | output | ACC_W | Signed result value |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
Assertions check on every cycle that enabled lanes never see a zero operand, that the tile stays frozen while a run is active, that the mode bits change only on an accepted start, that the result index steps by one, and that done and the drain phase follow their triggering events exactly. Only the bench scenarios can show the arithmetic itself: correct forward and backward sums, narrow-width truncation of both operands and weights, the extreme-magnitude sum, and the fact that writes and start pulses issued mid-run leave the results unchanged.

// File: rtl/wtile_pkg.sv
// Shared definitions for the transposable weight-tile engine.
package wtile_pkg;
    // Phases of one run: waiting, consuming operands, emitting results.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } run_state_t;
endpackage

// File: rtl/wtile_store.sv
// Weight tile storage with one write port and one wide read port that
// returns either a row (forward) or a column (backward) of the same array.
// Assumes: ROWS and COLS are at least 2; writes are blocked while lock is high.
module wtile_store #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int OPW  = 16,
    parameter int NL   = 8,
    parameter int IW   = 3,
    parameter int RW   = 3,
    parameter int CW   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_row,
    input  logic [CW-1:0]            wr_col,
    input  logic [OPW-1:0]           wr_data,
    input  logic                     lock,
    input  logic                     bwd,
    input  logic [IW-1:0]            idx,
    output logic [NL-1:0][OPW-1:0]   rd_vec
);
    logic [ROWS-1:0][COLS-1:0][OPW-1:0] mem;

    // Write one weight while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en && !lock && int'(wr_row) < ROWS && int'(wr_col) < COLS) begin
            mem[wr_row][wr_col] <= wr_data;
        end
    end

    // Select a row slice (forward) or a column slice (backward) for all lanes.
    always_comb begin
        rd_vec = '0;
        for (int j = 0; j < NL; j++) begin
            if (!bwd) begin
                if (j < COLS && int'(idx) < ROWS)
                    rd_vec[j] = mem[RW'(idx)][CW'(j)];
            end else begin
                if (j < ROWS && int'(idx) < COLS)
                    rd_vec[j] = mem[RW'(j)][CW'(idx)];
            end
        end
    end

    AST_TILE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem)); // R3
endmodule

// File: rtl/wtile_lanes.sv
// Parallel multiply-accumulate lanes, one per output entry.
// Assumes: OPW > 8 so that narrow mode can sign-extend the low byte.
module wtile_lanes #(
    parameter int NL    = 8,
    parameter int OPW   = 16,
    parameter int ACC_W = 35
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      en,
    input  logic                      narrow,
    input  logic [OPW-1:0]            op,
    input  logic [NL-1:0][OPW-1:0]    wv,
    output logic [NL-1:0][ACC_W-1:0]  acc
);
    localparam int PW = 2 * OPW;

    logic [OPW-1:0] op_x;

    // Apply the operand width selection to the streamed value.
    always_comb op_x = narrow ? {{(OPW-8){op[7]}}, op[7:0]} : op;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [OPW-1:0] w_x;
        logic [PW-1:0]  prod;

        // Width selection for the weight, then a signed product.
        always_comb begin
            w_x  = narrow ? {{(OPW-8){wv[g][7]}}, wv[g][7:0]} : wv[g];
            prod = PW'($signed(op_x) * $signed(w_x));
        end

        // Accumulate one product per enabled element; clear at run start.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                acc[g] <= '0;
            end else if (en) begin
                acc[g] <= acc[g] + {{(ACC_W-PW){prod[PW-1]}}, prod};
            end
        end
    end

    AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (op_x != '0)); // R5
    AST_NO_CLR_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !en); // R6
endmodule

// File: rtl/wtile_seq.sv
// Run sequencer: latches the mode at start, counts the streamed operands,
// then steps through the results and raises a done pulse.
// Assumes: every accepted operand is consumed in the cycle it arrives.
module wtile_seq
    import wtile_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int OPW  = 16,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bwd_in,
    input  logic            narrow_in,
    input  logic            in_valid,
    input  logic [OPW-1:0]  in_data,
    output logic            in_ready,
    output logic            clr,
    output logic            en,
    output logic            bwd,
    output logic            narrow,
    output logic            lock,
    output logic [IW-1:0]   idx,
    output logic            out_valid,
    output logic [IW-1:0]   out_idx,
    output logic            done
);
    run_state_t     st;
    logic [IW-1:0]  cnt;
    logic           done_q;
    logic [IW-1:0]  last_in;
    logic [IW-1:0]  last_out;
    logic           accept;
    logic           op_zero;

    // Vector lengths for the latched direction.
    always_comb begin
        last_in  = bwd ? IW'(COLS - 1) : IW'(ROWS - 1);
        last_out = bwd ? IW'(ROWS - 1) : IW'(COLS - 1);
    end

    // Handshake, zero detection and derived controls.
    always_comb begin
        in_ready  = (st == ST_STREAM);
        accept    = in_ready && in_valid;
        op_zero   = narrow ? (in_data[7:0] == 8'd0) : (in_data == '0);
        en        = accept && !op_zero;
        clr       = (st == ST_IDLE) && start;
        lock      = (st != ST_IDLE);
        idx       = cnt;
        out_valid = (st == ST_DRAIN);
        out_idx   = cnt;
        done      = done_q;
    end

    // Phase transitions and the element/result counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            bwd    <= 1'b0;
            narrow <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st     <= ST_STREAM;
                    cnt    <= '0;
                    bwd    <= bwd_in;
                    narrow <= narrow_in;
                end
                ST_STREAM: if (in_valid) begin
                    if (cnt == last_in) begin
                        st  <= ST_DRAIN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (cnt == last_out) begin
                        st     <= ST_IDLE;
                        cnt    <= '0;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bwd) |-> ($past(st) == ST_IDLE && $past(start))); // R8
    AST_DRAIN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cnt == last_in) |=> (out_valid && out_idx == '0)); // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + 1'b1)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && !out_valid && !in_ready)); // R7
endmodule

// File: rtl/wtile_mac_engine.sv
// Top of the transposable weight-tile MAC engine: storage, sequencer and
// accumulator lanes, with the result selected by the output index.
// Assumes: OPW > 8; ROWS, COLS >= 2.
module wtile_mac_engine #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int OPW  = 16,
    localparam int NL    = (ROWS > COLS) ? ROWS : COLS,
    localparam int IW    = $clog2(NL),
    localparam int RW    = $clog2(ROWS),
    localparam int CW    = $clog2(COLS),
    localparam int ACC_W = 2 * OPW + IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic [CW-1:0]     wr_col,
    input  logic [OPW-1:0]    wr_data,
    input  logic              start,
    input  logic              bwd_mode,
    input  logic              narrow_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OPW-1:0]    in_data,
    output logic              out_valid,
    output logic [IW-1:0]     out_idx,
    output logic [ACC_W-1:0]  out_data,
    output logic              done
);
    logic                     clr, en, bwd, narrow, lock;
    logic [IW-1:0]            idx;
    logic [NL-1:0][OPW-1:0]   rd_vec;
    logic [NL-1:0][ACC_W-1:0] acc;

    wtile_seq #(.ROWS(ROWS), .COLS(COLS), .OPW(OPW), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .bwd_in(bwd_mode),
        .narrow_in(narrow_mode), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .clr(clr), .en(en), .bwd(bwd), .narrow(narrow),
        .lock(lock), .idx(idx), .out_valid(out_valid), .out_idx(out_idx),
        .done(done)
    );

    wtile_store #(.ROWS(ROWS), .COLS(COLS), .OPW(OPW), .NL(NL), .IW(IW),
                  .RW(RW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .lock(lock), .bwd(bwd),
        .idx(idx), .rd_vec(rd_vec)
    );

    wtile_lanes #(.NL(NL), .OPW(OPW), .ACC_W(ACC_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .narrow(narrow),
        .op(in_data), .wv(rd_vec), .acc(acc)
    );

    // Present the accumulator named by the drain index.
    always_comb out_data = acc[out_idx];

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!in_ready && !out_valid && !done)); // R8
endmodule

// File: tb/wtile_mac_engine_bench.sv
module wtile_mac_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 8;
    localparam int COLS = 8;

    typedef struct packed {
        logic        bwd;
        logic        nar;
        logic [7:0]  zmask;
        logic [15:0] seed;
        logic        gap;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b0, 1'b0, 8'h00, 16'h1234, 1'b0},
        '{1'b1, 1'b0, 8'h00, 16'h7a5c, 1'b0},
        '{1'b0, 1'b1, 8'h00, 16'h3c81, 1'b0},
        '{1'b1, 1'b1, 8'h5a, 16'h9e37, 1'b1},
        '{1'b0, 1'b0, 8'ha5, 16'h0f0f, 1'b1},
        '{1'b1, 1'b0, 8'hff, 16'h4321, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_row = '0;
    logic [2:0]  wr_col = '0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;
    logic        bwd_mode = 1'b0;
    logic        narrow_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [2:0]  out_idx;
    logic [34:0] out_data;
    logic        done;

    int checks = 0;
    int failures = 0;
    logic [15:0] wm [ROWS][COLS];
    logic [15:0] xv [8];

    wtile_mac_engine u_wtile_mac_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .start(start),
        .bwd_mode(bwd_mode), .narrow_mode(narrow_mode), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_idx(out_idx), .out_data(out_data), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ext(input logic [15:0] v, input bit nar);
        return nar ? longint'($signed(v[7:0])) : longint'($signed(v));
    endfunction

    function automatic longint model(input int o, input bit bwd, input bit nar);
        longint s = 0;
        if (!bwd) for (int i = 0; i < ROWS; i++) s += ext(xv[i], nar) * ext(wm[i][o], nar);
        else      for (int j = 0; j < COLS; j++) s += ext(xv[j], nar) * ext(wm[o][j], nar);
        return s;
    endfunction

    task automatic load_w(input int i, input int j, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 3'(i); wr_col = 3'(j); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wm[i][j] = v;
    endtask

    // One full run; poke issues a write mid-stream (R3) and a start mid-drain (R8).
    task automatic run_vec(input bit bwd, input bit nar, input bit gap, input bit poke);
        int nin  = bwd ? COLS : ROWS;
        int nout = bwd ? ROWS : COLS;
        @(negedge clk);
        start = 1'b1; bwd_mode = bwd; narrow_mode = nar;
        @(negedge clk);
        start = 1'b0; bwd_mode = ~bwd; narrow_mode = ~nar;
        for (int k = 0; k < nin; k++) begin
            if (gap && k == 2) begin
                in_valid = 1'b0; in_data = 16'h7fff;
                @(negedge clk);
                chk(in_ready == 1'b1, "R9 ready held in gap", in_ready, 1);
            end
            in_valid = 1'b1; in_data = xv[k];
            if (poke && k == 4) begin
                wr_en = 1'b1; wr_row = 3'd0; wr_col = 3'd0; wr_data = 16'h5555;
            end
            chk(in_ready == 1'b1, "R5 ready every stream cycle", in_ready, 1);
            @(negedge clk);
            wr_en = 1'b0;
        end
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R5 out_valid right after last operand", out_valid, 1);
        for (int o = 0; o < nout; o++) begin
            if (poke && o == 2) start = 1'b1;
            chk(out_valid == 1'b1 && int'(out_idx) == o, "R7 result index order", out_idx, o);
            chk(longint'($signed(out_data)) == model(o, bwd, nar),
                bwd ? "R2 backward sum" : (nar ? "R4 narrow forward sum" : "R1 forward sum"),
                longint'($signed(out_data)), model(o, bwd, nar));
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1 && out_valid == 1'b0, "R7 done after last result", done, 1);
        chk(in_ready == 1'b0, "R8 start during run ignored", in_ready, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R8 reset state",
            {in_ready, out_valid, done}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                load_w(i, j, 16'((i * 8 + j) * 613 - 19000));

        // Table walk: R1 R2 R4 R5 R6 R9 across directions, widths, zeros and gaps.
        foreach (TBL[t]) begin
            for (int k = 0; k < 8; k++)
                xv[k] = TBL[t].zmask[k] ? 16'h0000
                      : (16'(TBL[t].seed * (k + 3)) ^ 16'(k * 4099));
            run_vec(TBL[t].bwd, TBL[t].nar, TBL[t].gap, 1'b0);
        end

        // R3: write during a run is dropped; rerun confirms the tile is untouched.
        for (int k = 0; k < 8; k++) xv[k] = 16'(k * 1111 + 7);
        run_vec(1'b0, 1'b0, 1'b0, 1'b1);
        run_vec(1'b1, 1'b0, 1'b0, 1'b0);

        // Extreme magnitude: every product is (-32768)^2, summed over eight rows.
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                load_w(i, j, 16'h8000);
        for (int k = 0; k < 8; k++) xv[k] = 16'h8000;
        run_vec(1'b0, 1'b0, 1'b0, 1'b0);
        chk(model(0, 1'b0, 1'b0) == 64'sd8589934592, "R1 extreme sum model",
            model(0, 1'b0, 1'b0), 64'sd8589934592);
        // R4: same data in narrow mode has a zero low byte, so every sum is 0.
        run_vec(1'b1, 1'b1, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule